// File: doc/BRIEF.md
# Packet Input Buffer with Burst Flow Control

This block is the front door of a packet-processing engine. A host DMA engine pushes 32-bit words into an input FIFO, and the processing core drains them through a read port. The block raises a registered ready flag, `host_rdy`, whenever the host may push one more burst of eight words. The host samples the flag, then writes a whole burst. That burst may be split over several DMA accesses. The host looks at the flag again only when the burst is complete.

Before the first data word of a packet, the host loads the packet length in words. The block counts accepted words in groups of eight and tracks how many words are still to come. A group starts with a remaining count of eight or fewer is the final group of the packet. The first accepted write of that group locks `host_rdy` low. The lock holds, whatever the free space, until a context-read strobe marks that the processed result has been collected. That strobe re-arms the block for the next packet.

Top module: `pkt_inbuf_flow`

## Requirements
- R1: After a synchronous reset, the buffer is empty, `rd_valid` and `ovf_err` are low, and `host_rdy` is high because the buffer depth is at least 16 words.
- R2: Outside the end-of-packet lock, `host_rdy` is high exactly when the buffer has at least 8 free words. The flag is registered. It shows the fill level as it stood after the previous clock edge, so it moves one cycle after the fill level.
- R3: An accepted write at a group boundary starts the final group when the remaining-word count before that write is 8 or fewer. Group boundaries fall every 8 accepted words, counted from the length load. One cycle after that write is registered, `host_rdy` goes low.
- R4: Once the final group has started, `host_rdy` stays low even after the buffer has drained, until a context-read strobe arrives.
- R5: A context-read strobe clears the lock, the remaining count and the group position. A write in the same cycle is still stored in the buffer but is not counted toward the packet.
- R6: A length load sets the remaining count and restarts the group position at a boundary, even partway through a packet. A write in the same cycle is stored but not counted.
- R7: Words leave the buffer in the order they were written. `rd_data` carries the word one cycle after an accepted read, and `rd_valid` pulses high with it. A read of an empty buffer is ignored.
- R8: A write to a full buffer is dropped, even when a read happens in the same cycle. The drop sets `ovf_err`, which stays high until reset.
- R9: A write and a read accepted in the same cycle leave the fill level unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| len_load | input | 1 | Load the packet length for the next packet |
| len_words | input | 12 | Packet length in words |
| wr_en | input | 1 | Host word write |
| wr_data | input | 32 | Host write data |
| rd_en | input | 1 | Core read request |
| rd_data | output | 32 | Word read out, valid with rd_valid |
| rd_valid | output | 1 | rd_data holds a newly read word |
| ctx_read | input | 1 | Context-read strobe that ends packet handling |
| host_rdy | output | 1 | Host may push one more 8-word burst |
| ovf_err | output | 1 | Sticky flag for a write dropped on a full buffer |

## Verification
Timing of each result, counted from a stimulus driven before clock edge k:
- A write or read changes the fill level at edge k.
- `host_rdy` reflects that change at edge k+1.
- A final-group write sets the lock at edge k and pulls `host_rdy` low at edge k+1.
- `rd_data`, `rd_valid` and `ovf_err` are due at edge k.

The bench holds a behavioural model with a queue and integer counters. The model advances at every rising edge from the same inputs, applying these latencies. Every design output is compared with the model at the following falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/pib_pkg.sv
package pib_pkg;
  // Words per host burst; the flow-control threshold and group size.
  localparam int unsigned PIB_GROUP = 8;
  localparam int unsigned PIB_WORD_W = 32;

  typedef logic [PIB_WORD_W-1:0] pib_word_t;

  // Tracker decision for one clock.
  typedef enum logic [1:0] {
    TRK_IDLE  = 2'd0,
    TRK_CLEAR = 2'd1,
    TRK_LOAD  = 2'd2,
    TRK_COUNT = 2'd3
  } trk_op_e;
endpackage

// File: rtl/pib_fifo.sv
module pib_fifo
  import pib_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  pib_word_t     wr_data,
  input  logic          rd_en,
  output pib_word_t     rd_data,
  output logic          rd_valid,
  output logic          wr_acc,
  output logic          wr_drop,
  output logic [CW-1:0] level
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_A  = AW'(DEPTH - 1);

  pib_word_t     mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          full, empty, rd_acc;

  assign full    = (count == DEPTH_C);
  assign empty   = (count == '0);
  assign wr_acc  = wr_en && !full;
  assign wr_drop = wr_en && full;
  assign rd_acc  = rd_en && !empty;
  assign level   = count;

  // Storage without reset, so a block RAM can hold it.
  always_ff @(posedge clk) begin
    if (wr_acc) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_acc) rd_data <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_acc;
      if (wr_acc) wptr <= (wptr == LAST_A) ? '0 : wptr + 1'b1;
      if (rd_acc) rptr <= (rptr == LAST_A) ? '0 : rptr + 1'b1;
      case ({wr_acc, rd_acc})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R8
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= DEPTH_C);

  // R9
  level_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && rd_acc) |=> (count == $past(count)));

  // R7
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !empty) |=> rd_valid);
endmodule

// File: rtl/pib_pkt_tracker.sv
module pib_pkt_tracker
  import pib_pkg::*;
#(
  parameter int unsigned LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctx_read,
  input  logic             len_load,
  input  logic [LEN_W-1:0] len_words,
  input  logic             wr_acc,
  output logic             eop_hold
);
  localparam int unsigned GW = $clog2(PIB_GROUP);
  localparam logic [LEN_W-1:0] GROUP_C = LEN_W'(PIB_GROUP);
  localparam logic [GW-1:0]    GLAST   = GW'(PIB_GROUP - 1);

  logic [LEN_W-1:0] remain;
  logic [GW-1:0]    grp_pos;
  logic             at_boundary, last_group;
  trk_op_e          op;

  // Priority: context read, then length load, then counting a write.
  always_comb begin
    if (ctx_read)      op = TRK_CLEAR;
    else if (len_load) op = TRK_LOAD;
    else if (wr_acc)   op = TRK_COUNT;
    else               op = TRK_IDLE;
  end

  assign at_boundary = (grp_pos == '0);
  assign last_group  = at_boundary && (remain <= GROUP_C);

  always_ff @(posedge clk) begin
    if (rst) begin
      remain   <= '0;
      grp_pos  <= '0;
      eop_hold <= 1'b0;
    end else begin
      case (op)
        TRK_CLEAR: begin
          remain   <= '0;
          grp_pos  <= '0;
          eop_hold <= 1'b0;
        end
        TRK_LOAD: begin
          remain  <= len_words;
          grp_pos <= '0;
        end
        TRK_COUNT: begin
          if (last_group) eop_hold <= 1'b1;
          if (remain != '0) remain <= remain - 1'b1;
          grp_pos <= (grp_pos == GLAST) ? '0 : grp_pos + 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R4
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (eop_hold && !ctx_read) |=> eop_hold);

  // R5
  ctx_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ctx_read |=> (!eop_hold && grp_pos == '0 && remain == '0));

  // R6
  len_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (len_load && !ctx_read) |=> (grp_pos == '0 && remain == $past(len_words)));
endmodule

// File: rtl/pib_ready_gen.sv
module pib_ready_gen
  import pib_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] level,
  input  logic          eop_hold,
  output logic          host_rdy
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] GROUP_C = CW'(PIB_GROUP);
  localparam logic          RST_RDY = (DEPTH >= PIB_GROUP);

  logic [CW-1:0] free_words;
  logic          space_ok;

  assign free_words = DEPTH_C - level;
  assign space_ok   = (free_words >= GROUP_C);

  always_ff @(posedge clk) begin
    if (rst) host_rdy <= RST_RDY;
    else     host_rdy <= space_ok && !eop_hold;
  end

  // R3
  hold_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    eop_hold |=> !host_rdy);

  // R2
  space_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (free_words < GROUP_C) |=> !host_rdy);
endmodule

// File: rtl/pkt_inbuf_flow.sv
module pkt_inbuf_flow
  import pib_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             len_load,
  input  logic [LEN_W-1:0] len_words,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  input  logic             rd_en,
  output logic [31:0]      rd_data,
  output logic             rd_valid,
  input  logic             ctx_read,
  output logic             host_rdy,
  output logic             ovf_err
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic          wr_acc, wr_drop, eop_hold;
  logic [CW-1:0] level;

  initial begin
    if (DEPTH < 2 * PIB_GROUP) $error("DEPTH must be at least 16 words");
  end

  pib_fifo #(.DEPTH(DEPTH), .CW(CW)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .wr_acc(wr_acc), .wr_drop(wr_drop), .level(level)
  );

  pib_pkt_tracker #(.LEN_W(LEN_W)) u_trk (
    .clk(clk), .rst(rst), .ctx_read(ctx_read), .len_load(len_load),
    .len_words(len_words), .wr_acc(wr_acc), .eop_hold(eop_hold)
  );

  pib_ready_gen #(.DEPTH(DEPTH), .CW(CW)) u_rdy (
    .clk(clk), .rst(rst), .level(level), .eop_hold(eop_hold),
    .host_rdy(host_rdy)
  );

  always_ff @(posedge clk) begin
    if (rst)          ovf_err <= 1'b0;
    else if (wr_drop) ovf_err <= 1'b1;
  end

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_err |=> ovf_err);
endmodule

// File: tb/pkt_inbuf_flow_test.sv
module pkt_inbuf_flow_test;
  localparam int DEPTH = 16;
  localparam int LEN_W = 12;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             len_load = 1'b0;
  logic [LEN_W-1:0] len_words = '0;
  logic             wr_en = 1'b0;
  logic [31:0]      wr_data = '0;
  logic             rd_en = 1'b0;
  logic             ctx_read = 1'b0;
  logic [31:0]      rd_data;
  logic             rd_valid, host_rdy, ovf_err;

  int checks = 0;
  int errors = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  pkt_inbuf_flow #(.DEPTH(DEPTH), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst(rst), .len_load(len_load), .len_words(len_words),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .rd_valid(rd_valid), .ctx_read(ctx_read), .host_rdy(host_rdy),
    .ovf_err(ovf_err)
  );

  // Behavioural reference model.
  logic [31:0] q[$];
  logic [31:0] m_rdat = '0;
  bit m_rvalid = 0, m_ovf = 0, m_rdy = 1, m_hold = 0;
  int m_rem = 0, m_grp = 0;
  bit model_live = 0;

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      m_rvalid = 0; m_ovf = 0; m_rdy = 1; m_hold = 0; m_rem = 0; m_grp = 0;
    end else begin
      bit wacc, racc;
      m_rdy = !m_hold && ((DEPTH - q.size()) >= 8);
      wacc = wr_en && (q.size() < DEPTH);
      racc = rd_en && (q.size() > 0);
      if (wr_en && !wacc) m_ovf = 1;
      m_rvalid = racc;
      if (racc) m_rdat = q.pop_front();
      if (wacc) q.push_back(wr_data);
      if (ctx_read) begin
        m_hold = 0; m_rem = 0; m_grp = 0;
      end else if (len_load) begin
        m_rem = int'(len_words); m_grp = 0;
      end else if (wacc) begin
        if (m_grp == 0 && m_rem <= 8) m_hold = 1;
        if (m_rem > 0) m_rem--;
        m_grp = (m_grp + 1) % 8;
      end
      model_live = 1;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare every output away from the active edge.
  always @(negedge clk) begin
    if (!rst && model_live) begin
      check(phase, "host_rdy", 32'(host_rdy), 32'(m_rdy));
      check("R8", "ovf_err", 32'(ovf_err), 32'(m_ovf));
      check("R7", "rd_valid", 32'(rd_valid), 32'(m_rvalid));
      if (m_rvalid) check("R7", "rd_data", rd_data, m_rdat);
    end
  end

  task automatic cyc(input bit w, input logic [31:0] d, input bit r,
                     input bit c = 0, input bit l = 0, input int lw = 0);
    wr_en = w; wr_data = d; rd_en = r; ctx_read = c; len_load = l;
    len_words = LEN_W'(lw);
    @(negedge clk);
    wr_en = 0; rd_en = 0; ctx_read = 0; len_load = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1", "reset host_rdy", 32'(host_rdy), 32'd1);
    check("R1", "reset ovf_err", 32'(ovf_err), 32'd0);
    check("R1", "reset rd_valid", 32'(rd_valid), 32'd0);
    idle(1);

    // R2: fill-level gating of the ready flag, 20-word packet.
    phase = "R2";
    cyc(0, 0, 0, 0, 1, 20);
    for (int i = 0; i < 8; i++) cyc(1, 32'h100 + i, 0);
    idle(2);
    for (int i = 0; i < 8; i++) cyc(1, 32'h200 + i, 0);
    idle(2);
    for (int i = 0; i < 8; i++) cyc(0, 0, 1);
    idle(2);

    // R3: third group has 4 words left, so its first write locks the flag.
    phase = "R3";
    for (int i = 0; i < 4; i++) cyc(1, 32'h300 + i, 0);
    idle(2);

    // R4: drain fully (plus reads on empty), flag must stay low.
    phase = "R4";
    for (int i = 0; i < 15; i++) cyc(0, 0, 1);
    idle(3);

    // R5: context read with a simultaneous write.
    phase = "R5";
    cyc(1, 32'h500, 0, 1);
    idle(3);
    cyc(0, 0, 1);
    idle(2);

    // R6: reload length mid-packet; the next write is a final-group start.
    phase = "R6";
    cyc(0, 0, 0, 0, 1, 20);
    for (int i = 0; i < 3; i++) cyc(1, 32'h600 + i, 0);
    cyc(0, 0, 0, 0, 1, 4);
    cyc(1, 32'h610, 0);
    idle(3);
    cyc(0, 0, 0, 1);
    for (int i = 0; i < 4; i++) cyc(0, 0, 1);
    idle(2);

    // R9: concurrent write and read.
    phase = "R9";
    cyc(0, 0, 0, 0, 1, 100);
    cyc(1, 32'h900, 0);
    for (int i = 0; i < 10; i++) cyc(1, 32'h901 + i, 1);
    idle(2);

    // R8: overflow, including a write with a read while full.
    phase = "R8";
    for (int i = 0; i < 18; i++) cyc(1, 32'h800 + i, 0);
    cyc(1, 32'h8AA, 1);
    idle(2);
    for (int i = 0; i < 17; i++) cyc(0, 0, 1);
    idle(2);

    // R1: reset clears the sticky error and restores the flag.
    phase = "R1";
    rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
    check("R1", "post-reset ovf_err", 32'(ovf_err), 32'd0);
    check("R1", "post-reset host_rdy", 32'(host_rdy), 32'd1);
    idle(3);
    finish_run();
  end
endmodule